// File: doc/BRIEF.md
# Serial Audio to Biphase-Mark Line Transmitter

This block accepts one stereo stream on a three-wire serial audio port (bit clock, word select, data) and sends it out as a single biphase-mark coded line carrying two 32-slot subframes per frame, one for the left sample and one for the right. The serial port may be framed in the I2S style, left-justified or right-justified. The sample width may be 16, 18, 20 or 24 bits. Every sample is placed MSB-aligned in a 24-bit audio field, so that narrower samples keep their full-scale meaning.

All logic runs on one oversampled encoder clock. The serial pins are synchronized into that domain and sampled on the rising edges of the bit clock. One half-slot of the line lasts `HALF_DIV` encoder clocks, so a frame of 64 slots takes `128*HALF_DIV` clocks. The integrator picks the encoder clock for each sample rate, from 24 kHz to 192 kHz. The line frame rate must be at least the audio frame rate. The transmitter always sends the latest complete left/right pair, and repeats it when no new pair has arrived.

Top module: `biphase_tx`

## Requirements
- R1: The serial bits are sampled on rising bit-clock edges. Format select 0 is I2S style: word select low means left, and the MSB comes one bit clock after word select changes. Format 1 (and 3) is left-justified: word select high means left, and the MSB is on the first bit clock after the change. Format 2 is right-justified: word select high means left, and the LSB is on the last bit clock before the change.
- R2: Width select 0/1/2/3 means 16/18/20/24-bit samples. A sample is placed MSB first into the 24-bit audio field, and the unused low bits are zero. Serial bits outside the sample window (padding) are ignored.
- R3: Each frame carries exactly one left/right pair: left in the first subframe, right in the second. A pair is taken whole at the frame boundary, every complete input pair reaches the line in input order, and a pair repeats while no newer one exists.
- R4: A subframe has 32 slots. Slots 0-3 hold the preamble. Slots 4-27 hold the audio field, LSB in slot 4. Slot 28 is validity, slot 29 is user and slot 30 is channel status. These three are constant parameters, zero by default.
- R5: Slot 31 is a parity bit chosen so that slots 4-31 contain an even number of ones.
- R6: In slots 4-31 the line changes level at the start of every slot, and changes again mid-slot exactly when the slot bit is 1.
- R7: Preamble half-slot levels, first half first, when the line was low just before the preamble: B = 11101000, M = 11100010, W = 11100100. The levels are inverted when the line was high.
- R8: Frames are numbered modulo 192, and the first frame after reset is frame 0. The left subframe of frame 0 uses preamble B, the other left subframes use M, and every right subframe uses W.
- R9: The line changes only on half-slot boundaries, which are `HALF_DIV` clocks apart. During reset the line is low. Until the first pair arrives, the audio fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampled encoder clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_i | input | 1 | Serial audio bit clock |
| wsel_i | input | 1 | Serial audio word select (channel framing) |
| sdata_i | input | 1 | Serial audio data |
| fmt_i | input | 2 | Framing select: 0 I2S style, 1/3 left-justified, 2 right-justified |
| width_i | input | 2 | Sample width select: 16/18/20/24 bits |
| line_o | output | 1 | Biphase-mark coded line output |

## Verification
On every cycle, the assertions check that the line level at each subframe start equals the level at the previous start, which follows from even parity and the fixed preamble toggle count. They also check the slot-boundary transition, that the line holds still between half-slot ticks, that B follows each block wrap, and that pairs leave the deserializer as single-cycle pulses. Only the bench scenarios can show the extraction itself: the correct bits picked for each framing and width while padding is ignored, LSB-first placement in the field, in-order delivery of every pair across format changes, and the 192-frame spacing of B. The bench decodes these from the line waveform alone.

// File: rtl/sa_pkg.sv
package sa_pkg;
  localparam int AUD_W = 24;

  typedef enum logic [1:0] {
    FMT_I2S = 2'd0,
    FMT_LJ  = 2'd1,
    FMT_RJ  = 2'd2,
    FMT_LJ2 = 2'd3
  } fmt_e;

  typedef enum logic [1:0] {
    PRE_B = 2'd0,
    PRE_M = 2'd1,
    PRE_W = 2'd2
  } pre_e;

  typedef struct packed {
    logic [AUD_W-1:0] left;
    logic [AUD_W-1:0] right;
  } pair_t;

  // Preamble as toggle masks: bit i set means the line flips at half-slot i.
  localparam logic [7:0] TOG_B = 8'b00111001;
  localparam logic [7:0] TOG_M = 8'b11001001;
  localparam logic [7:0] TOG_W = 8'b01101001;

  function automatic logic [4:0] width_of(input logic [1:0] sel);
    case (sel)
      2'd0:    width_of = 5'd16;
      2'd1:    width_of = 5'd18;
      2'd2:    width_of = 5'd20;
      default: width_of = 5'd24;
    endcase
  endfunction
endpackage

// File: rtl/sa_deser.sv
module sa_deser
  import sa_pkg::*;
#(
  parameter int SR_W = 40
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bclk,
  input  logic       wsel,
  input  logic       sdata,
  input  logic [1:0] fmt,
  input  logic [1:0] width,
  output pair_t      pair_o,
  output logic       pair_vld_o
);
  localparam int CNT_W = 8;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] SR_LIM  = CNT_W'(SR_W);

  logic [2:0]       bclk_s;
  logic [1:0]       ws_s, sd_s;
  logic             rise, ws_now, ws_prev, change, synced;
  logic [CNT_W-1:0] cnt, msb, sh;
  logic [4:0]       w;
  logic [SR_W-1:0]  sr, sr_nx;
  logic [AUD_W-1:0] mask, raw, aligned, l_hold;
  logic             ok, is_left;

  // Two-stage synchronizers; all three pins see the same delay.
  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_s <= '0;
      ws_s   <= '0;
      sd_s   <= '0;
    end else begin
      bclk_s <= {bclk_s[1:0], bclk};
      ws_s   <= {ws_s[0], wsel};
      sd_s   <= {sd_s[0], sdata};
    end
  end

  assign rise   = bclk_s[1] & ~bclk_s[2];
  assign ws_now = ws_s[1];
  assign change = rise && (ws_now != ws_prev);
  assign sr_nx  = {sr[SR_W-2:0], sd_s[1]};
  assign w      = width_of(width);

  // Position of the finished word's MSB inside sr_nx, per framing.
  always_comb begin
    case (fmt_e'(fmt))
      FMT_I2S: msb = cnt - CNT_W'(1);
      FMT_RJ:  msb = CNT_W'(w);
      default: msb = cnt;
    endcase
    ok      = (msb < SR_LIM) && ((msb + CNT_W'(1)) >= CNT_W'(w));
    sh      = msb + CNT_W'(1) - CNT_W'(w);
    mask    = (AUD_W'(1) << w) - AUD_W'(1);
    raw     = AUD_W'(sr_nx >> sh) & mask;
    aligned = raw << (5'd24 - w);
    is_left = (fmt_e'(fmt) == FMT_I2S) ? ~ws_prev : ws_prev;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr         <= '0;
      cnt        <= '0;
      ws_prev    <= 1'b0;
      synced     <= 1'b0;
      l_hold     <= '0;
      pair_o     <= '0;
      pair_vld_o <= 1'b0;
    end else begin
      pair_vld_o <= 1'b0;
      if (rise) begin
        sr      <= sr_nx;
        ws_prev <= ws_now;
        if (change)
          cnt <= CNT_W'(1);
        else if (cnt != CNT_MAX)
          cnt <= cnt + CNT_W'(1);
      end
      if (change) begin
        synced <= 1'b1;
        if (synced && ok) begin
          if (is_left) begin
            l_hold <= aligned;
          end else begin
            pair_o     <= '{left: l_hold, right: aligned};
            pair_vld_o <= 1'b1;
          end
        end
      end
    end
  end

  // R3: a finished pair is handed on as a single-cycle pulse
  assert_pair_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    pair_vld_o |=> !pair_vld_o);
endmodule

// File: rtl/sa_frame_seq.sv
module sa_frame_seq
  import sa_pkg::*;
#(
  parameter int HALF_DIV     = 2,
  parameter int BLOCK_FRAMES = 192
) (
  input  logic             clk,
  input  logic             rst,
  input  pair_t            pair_i,
  input  logic             pair_vld_i,
  output logic             tick_o,
  output logic [5:0]       hc_o,
  output pre_e             pre_o,
  output logic [AUD_W-1:0] aud_o
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int FR_W  = (BLOCK_FRAMES > 1) ? $clog2(BLOCK_FRAMES) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);
  localparam logic [FR_W-1:0]  FR_LAST  = FR_W'(BLOCK_FRAMES - 1);

  logic [DIV_W-1:0] div;
  logic [5:0]       hc;
  logic             sub;
  logic [FR_W-1:0]  fidx;
  pair_t            hold, cur;

  assign tick_o = (div == DIV_LAST);
  assign hc_o   = hc;
  assign aud_o  = sub ? cur.right : cur.left;
  assign pre_o  = sub ? PRE_W : ((fidx == '0) ? PRE_B : PRE_M);

  always_ff @(posedge clk) begin
    if (rst) begin
      div  <= '0;
      hc   <= '0;
      sub  <= 1'b0;
      fidx <= '0;
      hold <= '0;
      cur  <= '0;
    end else begin
      if (pair_vld_i) hold <= pair_i;
      div <= tick_o ? '0 : div + DIV_W'(1);
      if (tick_o) begin
        hc <= hc + 6'd1;
        if (hc == 6'd63) begin
          sub <= ~sub;
          if (sub) begin
            fidx <= (fidx == FR_LAST) ? '0 : fidx + FR_W'(1);
            cur  <= hold;
          end
        end
      end
    end
  end

  // R8: the frame after the last one of a block opens with preamble B
  assert_block_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    (tick_o && hc == 6'd63 && sub && fidx == FR_LAST) |=> (pre_o == PRE_B));
endmodule

// File: rtl/sa_bmc_line.sv
module sa_bmc_line
  import sa_pkg::*;
#(
  parameter bit VALID_BIT = 1'b0,
  parameter bit USER_BIT  = 1'b0,
  parameter bit CS_BIT    = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [5:0]       hc,
  input  pre_e             pre,
  input  logic [AUD_W-1:0] aud,
  output logic             line_o
);
  logic [4:0] slot;
  logic       slot_bit, parity, toggle, sf_lvl;
  logic [7:0] pre_vec;

  assign slot   = hc[5:1];
  assign parity = (^aud) ^ VALID_BIT ^ USER_BIT ^ CS_BIT;

  always_comb begin
    case (pre)
      PRE_B:   pre_vec = TOG_B;
      PRE_M:   pre_vec = TOG_M;
      default: pre_vec = TOG_W;
    endcase
    case (slot)
      5'd28:   slot_bit = VALID_BIT;
      5'd29:   slot_bit = USER_BIT;
      5'd30:   slot_bit = CS_BIT;
      5'd31:   slot_bit = parity;
      default: slot_bit = aud[5'(slot - 5'd4)];
    endcase
    if (hc < 6'd8)
      toggle = pre_vec[hc[2:0]];
    else if (!hc[0])
      toggle = 1'b1;
    else
      toggle = slot_bit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_o <= 1'b0;
      sf_lvl <= 1'b0;
    end else if (tick) begin
      line_o <= line_o ^ toggle;
      if (hc == 6'd0) sf_lvl <= line_o;
    end
  end

  // R5: even parity plus four preamble toggles return the line to its start level
  assert_even_subframe_R5: assert property (@(posedge clk) disable iff (rst)
    (tick && hc == 6'd0) |-> (line_o == sf_lvl));

  // R6: every data slot starts with a transition
  assert_slot_edge_R6: assert property (@(posedge clk) disable iff (rst)
    (tick && hc >= 6'd8 && !hc[0]) |=> (line_o != $past(line_o)));

  // R9: the line only moves on half-slot ticks
  assert_hold_between_ticks_R9: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(line_o));
endmodule

// File: rtl/biphase_tx.sv
module biphase_tx
  import sa_pkg::*;
#(
  parameter int HALF_DIV     = 2,
  parameter int SR_W         = 40,
  parameter int BLOCK_FRAMES = 192,
  parameter bit VALID_BIT    = 1'b0,
  parameter bit USER_BIT     = 1'b0,
  parameter bit CS_BIT       = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bclk_i,
  input  logic       wsel_i,
  input  logic       sdata_i,
  input  logic [1:0] fmt_i,
  input  logic [1:0] width_i,
  output logic       line_o
);
  pair_t            pair;
  logic             pair_vld;
  logic             tick;
  logic [5:0]       hc;
  pre_e             pre;
  logic [AUD_W-1:0] aud;

  sa_deser #(.SR_W(SR_W)) u_deser (
    .clk       (clk),
    .rst       (rst),
    .bclk      (bclk_i),
    .wsel      (wsel_i),
    .sdata     (sdata_i),
    .fmt       (fmt_i),
    .width     (width_i),
    .pair_o    (pair),
    .pair_vld_o(pair_vld)
  );

  sa_frame_seq #(.HALF_DIV(HALF_DIV), .BLOCK_FRAMES(BLOCK_FRAMES)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .pair_i    (pair),
    .pair_vld_i(pair_vld),
    .tick_o    (tick),
    .hc_o      (hc),
    .pre_o     (pre),
    .aud_o     (aud)
  );

  sa_bmc_line #(.VALID_BIT(VALID_BIT), .USER_BIT(USER_BIT), .CS_BIT(CS_BIT)) u_line (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick),
    .hc    (hc),
    .pre   (pre),
    .aud   (aud),
    .line_o(line_o)
  );
endmodule

// File: tb/tb_biphase_tx.sv
`timescale 1ns/1ps
module tb_biphase_tx;
  localparam int HD = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, bclk, wsel, sdata, line;
  logic [1:0] fmt, width;

  biphase_tx #(.HALF_DIV(HD)) dut (
    .clk(clk), .rst(rst), .bclk_i(bclk), .wsel_i(wsel), .sdata_i(sdata),
    .fmt_i(fmt), .width_i(width), .line_o(line)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [47:0] expq[$];
  logic hq[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int wid(input logic [1:0] s);
    case (s) 2'd0: return 16; 2'd1: return 18; 2'd2: return 20; default: return 24; endcase
  endfunction

  // ---------------- driver ----------------
  task automatic send_bit(input logic ws, input logic d);
    bclk = 1'b0; wsel = ws; sdata = d;
    repeat (3) @(negedge clk);
    bclk = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_half(input logic [23:0] s, input bit right, input bit zero);
    int w = wid(width);
    logic chws, ws, d;
    for (int k = 0; k < 32; k++) begin
      if (fmt == 2'd0) begin
        chws = right;
        ws = (k == 31) ? ~chws : chws;
      end else begin
        chws = ~right;
        ws = chws;
      end
      d = zero ? 1'b0 : 1'b1;            // padding bits, to be ignored (R2)
      if (fmt == 2'd2) begin
        if (k >= 32 - w) d = s[31-k];
      end else begin
        if (k < w) d = s[w-1-k];
      end
      send_bit(ws, d);
    end
  endtask

  task automatic send_frame(input logic [23:0] l, input logic [23:0] r, input bit zero);
    send_half(l, 1'b0, zero);
    send_half(r, 1'b1, zero);
  endtask

  task automatic run_segment(input logic [1:0] f, input logic [1:0] ws_sel, input int n);
    int w;
    logic [23:0] m, rl, rr;
    fmt = f; width = ws_sel;
    w = wid(ws_sel);
    m = 24'((64'd1 << w) - 1);
    send_frame(24'd0, 24'd0, 1'b1);
    for (int i = 0; i < n; i++) begin
      rl = 24'($urandom) & m; rl[0] = 1'b1;
      rr = 24'($urandom) & m; rr[1] = 1'b1;
      expq.push_back({rl << (24 - w), rr << (24 - w)});
      send_frame(rl, rr, 1'b0);
    end
    send_frame(24'd0, 24'd0, 1'b1);
  endtask

  // ---------------- line to half-slot stream ----------------
  initial begin
    logic lvl = 1'b0;
    int run = 0;
    int n;
    forever begin
      @(negedge clk);
      if (line === lvl) run++;
      else begin
        n = (run + HD / 2) / HD;
        if (n < 1) n = 1;
        if (n > 8) n = 8;
        for (int i = 0; i < n; i++) hq.push_back(lvl);
        lvl = line;
        run = 1;
      end
    end
  end

  task automatic pop_half(output logic v);
    while (hq.size() == 0) @(negedge clk);
    v = hq.pop_front();
  endtask

  function automatic int pmatch(input logic [8:0] s);
    logic [7:0] rel;
    rel = s[7:0] ^ {8{s[8]}};
    if (rel == 8'b11101000) return 0;
    if (rel == 8'b11100010) return 1;
    if (rel == 8'b11100100) return 2;
    return -1;
  endfunction

  // ---------------- monitor / scoreboard ----------------
  logic [23:0] cur_l;
  bit have_l = 0;
  int fcnt = 0;
  bit first_sub = 1;
  logic [47:0] last_pair = '0;

  task automatic handle_sub(input int pt, input logic [23:0] aud);
    logic [47:0] pr;
    if (first_sub) begin
      chk(pt == 0, "R8", "first subframe after reset uses B", pt, 0);
      first_sub = 0;
    end
    if (pt != 2) begin
      chk((pt == 0) == (fcnt % 192 == 0), "R8", "B only on frame 0 of 192", pt, fcnt % 192);
      cur_l = aud; have_l = 1;
    end else begin
      chk(have_l, "R3", "right subframe follows a left one", have_l, 1);
      have_l = 0;
      fcnt++;
      pr = {cur_l, aud};
      if (expq.size() > 0 && pr == expq[0]) begin
        void'(expq.pop_front());
        chk(1'b1, "R1 R2 R3", "pair match", pr, pr);
        last_pair = pr;
      end else if (pr != last_pair && pr != '0) begin
        chk(1'b0, "R1 R2 R3", "unexpected pair", pr, (expq.size() > 0) ? expq[0] : 48'd0);
      end
    end
  endtask

  initial begin
    logic [8:0] sh = '0;
    logic a, b, last;
    logic [27:0] bits;
    bit edges_ok, insync;
    int pt;
    forever begin
      pt = -1;
      while (pt < 0) begin
        pop_half(a);
        sh = {sh[7:0], a};
        pt = pmatch(sh);
      end
      insync = 1;
      while (insync) begin
        last = sh[0];
        edges_ok = 1;
        for (int s = 0; s < 28; s++) begin
          pop_half(a); pop_half(b);
          if (a == last) edges_ok = 0;
          bits[s] = a ^ b;
          last = b;
        end
        chk(edges_ok, "R6", "transition at every slot start", edges_ok, 1);
        chk(^bits == 1'b0, "R5", "even parity over slots 4-31", ^bits, 0);
        chk(bits[26:24] == 3'b000, "R4", "validity/user/status slots", bits[26:24], 0);
        handle_sub(pt, bits[23:0]);
        sh = {8'd0, last};
        for (int i = 0; i < 8; i++) begin
          pop_half(a);
          sh = {sh[7:0], a};
        end
        pt = pmatch(sh);
        chk(pt >= 0, "R7", "valid preamble pattern", sh, 0);
        if (pt < 0) insync = 0;
      end
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    rst = 1'b1; bclk = 1'b0; wsel = 1'b0; sdata = 1'b0; fmt = 2'd0; width = 2'd3;
    repeat (10) @(negedge clk);
    chk(line == 1'b0, "R9", "line low in reset", line, 0);
    rst = 1'b0;
    run_segment(2'd0, 2'd3, 38);   // R1 I2S style, 24 bit
    run_segment(2'd1, 2'd0, 38);   // R1 left-justified, R2 16 bit
    run_segment(2'd2, 2'd1, 38);   // R1 right-justified, R2 18 bit
    run_segment(2'd0, 2'd2, 38);   // R2 20 bit
    run_segment(2'd2, 2'd3, 38);
    run_segment(2'd1, 2'd3, 38);
    repeat (3000) @(negedge clk);
    chk(expq.size() == 0, "R3", "every pair delivered", expq.size(), 0);
    chk(fcnt > 192, "R8", "run covered a block wrap", fcnt, 193);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R3 actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule